// File: doc/BRIEF.md
# Exception-Aware Dispatch Queue

This block is a circular queue between a rename stage and an issue stage. Each cycle the rename side offers a group of up to four micro-ops. Every slot in the group has a valid bit, an exception flag and a 16-bit payload. The issue side can take up to two micro-ops per cycle, oldest first, from the head of the queue.

The enqueue logic writes only the micro-ops that can really enter the queue. An excepting micro-op is never stored. Every later slot in the same group is also held back. The surviving slots are packed into consecutive entries starting at the tail. The tail pointer then advances by exactly the number of entries written, so a reserved entry is never left empty.

A group is accepted only when at least four entries are free. A flush input empties the queue at the next clock edge.

Top module: `dispatch_queue`

## Requirements
- R1: After reset, occupancy is 0, both deqValid bits are 0 and enqReady is 1.
- R2: enqReady is 1 exactly when flush is low and free entries (16 minus occupancy) number at least 4. While enqReady is 0, the offered group is ignored and occupancy does not grow.
- R3: A slot with enqValid and enqExcept both set is never written into the queue.
- R4: A slot after the first slot that has enqValid and enqExcept both set is blocked, even if its own exception flag is clear. A slot whose enqValid is 0 blocks nothing, whatever its exception flag.
- R5: Slots that are written go into consecutive entries starting at the tail, in slot order (slot 0 first), with no gaps. Invalid slots are skipped. The payload of slot i sits at enqPayload bits 16*i+15 down to 16*i.
- R6: Occupancy, and with it the tail, advances by the number of micro-ops actually written, not by the number of slots offered.
- R7: deqValid[i] is 1 exactly when occupancy is greater than i. deqPayload bits 16*i+15 down to 16*i then hold the i-th oldest entry.
- R8: Dequeue takes only the leading run of set deqAccept bits whose deqValid is also 1. A set bit that follows a clear or invalid one is ignored. The head advances by the number taken.
- R9: Flush empties the queue at the next clock edge. It overrides any enqueue or dequeue in that cycle.
- R10: The queue can hold 16 entries, and order is kept across pointer wraparound.
- R11: When enqueue and dequeue happen in the same cycle, the new occupancy is the old occupancy plus the number written minus the number taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue at the next edge |
| enqValid | input | 4 | Per-slot valid bits of the offered group |
| enqExcept | input | 4 | Per-slot exception flags |
| enqPayload | input | 64 | Slot payloads, 16 bits per slot |
| enqReady | output | 1 | Group is accepted this cycle |
| deqAccept | input | 2 | Issue side takes the oldest entries |
| deqValid | output | 2 | Oldest entries are present |
| deqPayload | output | 32 | Payloads of the two oldest entries |
| occupancy | output | 5 | Number of entries held |

## Verification
The assertions assume that flush and rst_n are never asserted together in a way that matters, and that the issue side does not depend on deqPayload when deqValid is low. The pointer and occupancy checks assume the depth is a power of two, so that index arithmetic wraps on its own. The stimulus changes inputs only on falling edges. It offers groups freely, including while enqReady is low, because the block must ignore those groups itself.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int unsigned ENQ_W = 4;
  localparam int unsigned DEQ_W = 2;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned PAY_W = 16;

  localparam int unsigned IDX_W     = $clog2(DEPTH);
  localparam int unsigned PTR_W     = IDX_W + 1;
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1);
  localparam int unsigned ENQ_CNT_W = $clog2(ENQ_W + 1);
  localparam int unsigned DEQ_CNT_W = $clog2(DEQ_W + 1);

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [PTR_W-1:0] ptr_t;
  typedef logic [PAY_W-1:0] payload_t;

  typedef struct packed {
    logic [ENQ_W-1:0] wrMask;
    idx_t             tailIdx;
    idx_t             headIdx;
  } dq_strobe_t;
endpackage

// File: rtl/dq_ctrl.sv
module dq_ctrl
  import dq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [ENQ_W-1:0] enqValid,
  input  logic [ENQ_W-1:0] enqExcept,
  input  logic [DEQ_W-1:0] deqAccept,
  output logic             enqReady,
  output logic [DEQ_W-1:0] deqValid,
  output logic [CNT_W-1:0] occupancy,
  output dq_strobe_t       strobe
);
  ptr_t                 headPtr;
  ptr_t                 tailPtr;
  logic [ENQ_W-1:0]     wrMask;
  logic [ENQ_CNT_W-1:0] wrCount;
  logic [DEQ_W-1:0]     deqTake;
  logic [DEQ_CNT_W-1:0] deqCount;
  logic [CNT_W-1:0]     freeSlots;

  assign freeSlots = CNT_W'(DEPTH) - occupancy;
  assign enqReady  = !flush && (freeSlots >= CNT_W'(ENQ_W));

  // Cut enqueue off at the first valid excepting slot
  always_comb begin : enq_cut
    logic excSeen;
    excSeen = 1'b0;
    wrCount = '0;
    for (int i = 0; i < ENQ_W; i++) begin
      wrMask[i] = enqReady && enqValid[i] && !enqExcept[i] && !excSeen;
      excSeen   = excSeen || (enqValid[i] && enqExcept[i]);
      wrCount   = wrCount + ENQ_CNT_W'(wrMask[i]);
    end
  end

  for (genvar g = 0; g < DEQ_W; g++) begin : g_deqValid
    assign deqValid[g] = occupancy > CNT_W'(g);
  end

  // Leading-prefix dequeue
  always_comb begin : deq_prefix
    logic takeOk;
    takeOk   = !flush;
    deqCount = '0;
    for (int i = 0; i < DEQ_W; i++) begin
      deqTake[i] = takeOk && deqValid[i] && deqAccept[i];
      takeOk     = deqTake[i];
      deqCount   = deqCount + DEQ_CNT_W'(deqTake[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      occupancy <= '0;
    end else begin
      tailPtr   <= tailPtr + PTR_W'(wrCount);
      headPtr   <= headPtr + PTR_W'(deqCount);
      occupancy <= occupancy + CNT_W'(wrCount) - CNT_W'(deqCount);
    end
  end

  assign strobe.wrMask  = wrMask;
  assign strobe.tailIdx = tailPtr[IDX_W-1:0];
  assign strobe.headIdx = headPtr[IDX_W-1:0];

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(DEPTH));

  // R6
  ptr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy == CNT_W'(ptr_t'(tailPtr - headPtr)));

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occupancy == '0) && (headPtr == tailPtr));

  // R2
  hold_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !enqReady) |=> tailPtr == $past(tailPtr));

  // R3
  exc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && enqValid[0] && enqExcept[0]) |=> tailPtr == $past(tailPtr));

  // R8
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> ptr_t'(headPtr - $past(headPtr)) <= PTR_W'(DEQ_W));
endmodule

// File: rtl/dq_data.sv
module dq_data
  import dq_pkg::*;
(
  input  logic                   clk,
  input  dq_strobe_t             strobe,
  input  logic [ENQ_W*PAY_W-1:0] enqPayload,
  output logic [DEQ_W*PAY_W-1:0] deqPayload
);
  payload_t mem [DEPTH];
  idx_t     slotAddr [ENQ_W];

  // Packed placement: each written slot lands after the previous written one
  always_comb begin : place
    idx_t off;
    off = '0;
    for (int i = 0; i < ENQ_W; i++) begin
      slotAddr[i] = strobe.tailIdx + off;
      off         = off + idx_t'(strobe.wrMask[i]);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENQ_W; i++) begin
      if (strobe.wrMask[i]) mem[slotAddr[i]] <= enqPayload[i*PAY_W +: PAY_W];
    end
  end

  for (genvar g = 0; g < DEQ_W; g++) begin : g_read
    assign deqPayload[g*PAY_W +: PAY_W] = mem[strobe.headIdx + idx_t'(g)];
  end
endmodule

// File: rtl/dispatch_queue.sv
module dispatch_queue
  import dq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [ENQ_W-1:0]       enqValid,
  input  logic [ENQ_W-1:0]       enqExcept,
  input  logic [ENQ_W*PAY_W-1:0] enqPayload,
  output logic                   enqReady,
  input  logic [DEQ_W-1:0]       deqAccept,
  output logic [DEQ_W-1:0]       deqValid,
  output logic [DEQ_W*PAY_W-1:0] deqPayload,
  output logic [CNT_W-1:0]       occupancy
);
  dq_strobe_t strobe;

  dq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .enqValid(enqValid), .enqExcept(enqExcept), .deqAccept(deqAccept),
    .enqReady(enqReady), .deqValid(deqValid), .occupancy(occupancy),
    .strobe(strobe)
  );

  dq_data u_data (
    .clk(clk), .strobe(strobe),
    .enqPayload(enqPayload), .deqPayload(deqPayload)
  );
endmodule

// File: tb/dispatch_queue_tb.sv
`timescale 1ns/1ps
module dispatch_queue_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [3:0]  enqValid = '0;
  logic [3:0]  enqExcept = '0;
  logic [63:0] enqPayload = '0;
  logic        enqReady;
  logic [1:0]  deqAccept = '0;
  logic [1:0]  deqValid;
  logic [31:0] deqPayload;
  logic [4:0]  occupancy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] model[$];

  always #2 clk = ~clk;

  dispatch_queue u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .enqValid(enqValid), .enqExcept(enqExcept), .enqPayload(enqPayload),
    .enqReady(enqReady), .deqAccept(deqAccept), .deqValid(deqValid),
    .deqPayload(deqPayload), .occupancy(occupancy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_out(input string req);
    chk(occupancy == 5'(model.size()), req, occupancy, model.size());
    for (int i = 0; i < 2; i++) begin
      chk(deqValid[i] == (model.size() > i), "R7", deqValid[i], model.size() > i);
      if (model.size() > i)
        chk(deqPayload[i*16 +: 16] == model[i], req, deqPayload[i*16 +: 16], model[i]);
    end
  endtask

  // One cycle: drive at negedge, predict from requirements, check after the edge
  task automatic step(input logic [3:0] v, input logic [3:0] e, input logic [63:0] p,
                      input logic [1:0] acc, input logic fl, input string req);
    logic [15:0] wr[$];
    bit rdy, stop, ok;
    int ntake;
    @(negedge clk);
    enqValid = v; enqExcept = e; enqPayload = p; deqAccept = acc; flush = fl;
    #1;
    rdy = !fl && (16 - model.size() >= 4);
    chk(enqReady == rdy, "R2", enqReady, rdy);
    ok = 1'b1; ntake = 0;
    for (int i = 0; i < 2; i++) begin
      if (ok && acc[i] && model.size() > i) ntake++; else ok = 1'b0;
    end
    stop = 1'b0;
    if (rdy) begin
      for (int i = 0; i < 4; i++) begin
        if (v[i] && e[i]) stop = 1'b1;
        else if (v[i] && !stop) wr.push_back(p[i*16 +: 16]);
      end
    end
    if (fl) model.delete();
    else begin
      for (int i = 0; i < ntake; i++) void'(model.pop_front());
      foreach (wr[i]) model.push_back(wr[i]);
    end
    @(posedge clk); #1;
    check_out(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(4'b0, 4'b0, 64'h0, 2'b00, 1'b0, "R7");
  endtask

  task automatic drain();
    while (model.size() > 0) step(4'b0, 4'b0, 64'h0, 2'b11, 1'b0, "R8");
  endtask

  task automatic t_reset();
    chk(occupancy == 0, "R1", occupancy, 0);
    chk(deqValid == 2'b00, "R1", deqValid, 0);
    chk(enqReady == 1'b1, "R1", enqReady, 1);
  endtask

  task automatic t_full_group();  // R5 R6
    step(4'b1111, 4'b0000, 64'hA003_A002_A001_A000, 2'b00, 1'b0, "R5");
    drain();
  endtask

  task automatic t_exc_mid();  // R3 R4
    step(4'b1111, 4'b0100, 64'hB003_B002_B001_B000, 2'b00, 1'b0, "R4");
    chk(occupancy == 2, "R4", occupancy, 2);
    drain();
  endtask

  task automatic t_exc_first();  // R3
    step(4'b1111, 4'b0001, 64'hC003_C002_C001_C000, 2'b00, 1'b0, "R3");
    chk(occupancy == 0, "R3", occupancy, 0);
  endtask

  task automatic t_gap();  // R5 R6
    step(4'b1101, 4'b0000, 64'hD003_D002_D001_D000, 2'b00, 1'b0, "R6");
    chk(occupancy == 3, "R6", occupancy, 3);
    drain();
  endtask

  task automatic t_invalid_exc();  // R4
    step(4'b0011, 4'b1100, 64'hE003_E002_E001_E000, 2'b00, 1'b0, "R4");
    chk(occupancy == 2, "R4", occupancy, 2);
  endtask

  task automatic t_prefix();  // R8
    step(4'b1111, 4'b0000, 64'hF003_F002_F001_F000, 2'b10, 1'b0, "R8");
    step(4'b0, 4'b0, 64'h0, 2'b01, 1'b0, "R8");
    step(4'b0, 4'b0, 64'h0, 2'b10, 1'b0, "R8");
    drain();
  endtask

  task automatic t_fill();  // R2 R10
    for (int g = 0; g < 4; g++)
      step(4'b1111, 4'b0, {16'(g*4+3), 16'(g*4+2), 16'(g*4+1), 16'(g*4)}, 2'b00, 1'b0, "R10");
    chk(occupancy == 16, "R10", occupancy, 16);
    step(4'b1111, 4'b0, 64'h9999_9999_9999_9999, 2'b00, 1'b0, "R2");
    step(4'b1111, 4'b0, 64'h8888_8888_8888_8888, 2'b11, 1'b0, "R2");
    chk(occupancy == 14, "R2", occupancy, 14);
    drain();
  endtask

  task automatic t_simul();  // R11
    step(4'b0111, 4'b0, 64'h0000_7702_7701_7700, 2'b00, 1'b0, "R11");
    step(4'b1111, 4'b1000, 64'h7706_7705_7704_7703, 2'b11, 1'b0, "R11");
    chk(occupancy == 4, "R11", occupancy, 4);
    drain();
  endtask

  task automatic t_wrap();  // R10
    for (int k = 0; k < 24; k++)
      step(4'b0011, 4'b0, {32'h0, 16'(16'h5000 + k*2 + 1), 16'(16'h5000 + k*2)},
           (k % 3 == 0) ? 2'b01 : 2'b11, 1'b0, "R10");
    drain();
  endtask

  task automatic t_flush();  // R9
    step(4'b1111, 4'b0, 64'h4403_4402_4401_4400, 2'b00, 1'b0, "R9");
    step(4'b1111, 4'b0, 64'h4407_4406_4405_4404, 2'b11, 1'b1, "R9");
    chk(occupancy == 0, "R9", occupancy, 0);
    step(4'b0011, 4'b0, 64'h0000_0000_4411_4410, 2'b00, 1'b0, "R9");
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset();
    t_full_group();
    t_exc_mid();
    t_exc_first();
    t_gap();
    t_invalid_exc();
    t_prefix();
    t_fill();
    t_simul();
    t_wrap();
    t_flush();
    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule